// File: doc/BRIEF.md
# Cascadable serial-to-parallel latch register

The block turns a serial bit stream into a parallel word in two steps. Each rising edge on a shift-clock input moves every bit one stage along a chain and loads the serial input into the first stage. Each rising edge on a separate storage-clock input copies the whole chain into a holding register. The holding register feeds a parallel output bus. The last chain stage is also brought out as a serial output, so several instances can be daisy-chained to build a longer word.

All logic runs on one system clock. The shift clock, storage clock, serial data, clear and output-enable pins are treated as slow external signals. Each one passes through a two-flop synchroniser. A clock event is a rising transition seen between two consecutive synchronised samples.

An active-low clear empties only the shift chain. An active-low output enable decides whether the parallel bus is driven. Pad-level tri-state is modelled as a per-bit drive-enable bus next to the data bus.

Top module: `serial_latch_reg`

## Requirements
- R1: On each shift-clock rising edge, stage 0 takes the serial input and each stage k (k>0) takes the old value of stage k-1. Bits are sent most significant first, so after WIDTH shifts and one store, `par_data[WIDTH-1]` holds the first bit sent.
- R2: On each storage-clock rising edge, the holding register takes the current chain contents. Without a storage edge, `par_data` does not change.
- R3: `ser_out` always equals the last chain stage (stage WIDTH-1), which is the value stage WIDTH-2 held before the latest shift.
- R4: While `clear_n` is low, the chain is held at all zeros and shift edges are ignored. The holding register keeps its value.
- R5: While `clear_n` is low, `ser_out` reads 0.
- R6: A storage edge that arrives while `clear_n` is low loads all zeros into the holding register.
- R7: `par_drive` is all ones while `oe_n` is low and all zeros while `oe_n` is high. `par_data` always carries the holding register. A bit whose drive is 0 counts as high impedance.
- R8: `oe_n` has no effect on shifting, storage transfer or `ser_out`.
- R9: When a shift edge and a storage edge fall in the same sampled cycle, the holding register takes the chain contents from before that shift.
- R10: A clock input held high causes exactly one action. Only a low-to-high transition counts.
- R11: After system reset, the chain, the holding register and `ser_out` are all zero.
- R12: An input change is sampled by two synchroniser flops. The resulting register update appears at the outputs after the third system-clock rising edge that follows the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | system reset, active low, asynchronous |
| shift_clk_in | input | 1 | shift clock, acts on rising transitions |
| store_clk_in | input | 1 | storage clock, acts on rising transitions |
| ser_in | input | 1 | serial data input |
| clear_n | input | 1 | chain clear, active low |
| oe_n | input | 1 | parallel output enable, active low |
| ser_out | output | 1 | last chain stage, used for cascading |
| par_data | output | WIDTH | holding register contents |
| par_drive | output | WIDTH | per-bit drive enable of the parallel bus |

## Verification
The hardest case to produce is a shift edge and a storage edge landing in the same synchronised cycle. In that case the holding register must capture the word from before the shift. The bench raises both pins on the same falling clock edge, so both pass through identical synchroniser stages and are seen together. It then compares the stored word with its model of the chain as it stood before that shift.

A storage edge issued during a clear is reached the same way: the clear is held low while a lone storage pulse is applied.

// File: rtl/slr_pkg.sv
package slr_pkg;
  // positions inside the synchronised control vector
  localparam int CI_SHIFT = 0;
  localparam int CI_STORE = 1;
  localparam int CI_DATA  = 2;
  localparam int CI_CLR   = 3;
  localparam int CI_OE    = 4;
  localparam int CI_COUNT = 5;

  // idle levels: clocks and data low, the active-low controls high
  localparam logic [CI_COUNT-1:0] CI_IDLE = 5'b11000;

  // next chain value after one shift
  function automatic logic [63:0] chain_step(input logic [63:0] cur, input logic din);
    return {cur[62:0], din};
  endfunction

  // value the holding register takes on a storage event
  function automatic logic [63:0] store_value(input logic [63:0] cur, input logic clr_act);
    return clr_act ? 64'd0 : cur;
  endfunction
endpackage

// File: rtl/slr_sync_bank.sv
module slr_sync_bank #(
  parameter int N = 5,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  logic [N-1:0] meta;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i]   <= IDLE[i];
        synced[i] <= IDLE[i];
      end else begin
        meta[i]   <= raw[i];
        synced[i] <= meta[i];
      end
    end
  end
endmodule

// File: rtl/slr_edge_bank.sv
module slr_edge_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev[i];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]); // R10
  end
endmodule

// File: rtl/slr_shift_chain.sv
module slr_shift_chain
  import slr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_ev,
  input  logic             din,
  input  logic             clr_act,
  output logic [WIDTH-1:0] chain,
  output logic             tail
);
  logic [63:0] wide_next;

  always_comb begin
    wide_next = chain_step(64'(chain), din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain <= '0;
    else if (clr_act)  chain <= '0;
    else if (shift_ev) chain <= wide_next[WIDTH-1:0];
  end

  assign tail = chain[WIDTH-1];

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !clr_act) |=> chain[WIDTH-1:1] == $past(chain[WIDTH-2:0])); // R1

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> chain == '0); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_ev && !clr_act) |=> $stable(chain)); // R10
endmodule

// File: rtl/slr_hold_bank.sv
module slr_hold_bank
  import slr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_ev,
  input  logic             clr_act,
  input  logic [WIDTH-1:0] chain_in,
  output logic [WIDTH-1:0] hold
);
  logic [63:0] wide_val;

  always_comb begin
    wide_val = store_value(64'(chain_in), clr_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold <= '0;
    else if (store_ev) hold <= wide_val[WIDTH-1:0];
  end

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !store_ev |=> $stable(hold)); // R2

  AST_CLEAR_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ev && clr_act) |=> hold == '0); // R6
endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg
  import slr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk_in,
  input  logic             store_clk_in,
  input  logic             ser_in,
  input  logic             clear_n,
  input  logic             oe_n,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_data,
  output logic [WIDTH-1:0] par_drive
);
  localparam int NCLK = 2;

  logic [CI_COUNT-1:0] raw_ctl;
  logic [CI_COUNT-1:0] syn_ctl;
  logic [NCLK-1:0]     clk_rise;

  // named internal events for the checks
  logic             shift_ev;
  logic             store_ev;
  logic             clr_act;
  logic             din_s;
  logic [WIDTH-1:0] chain;
  logic [WIDTH-1:0] hold;
  logic             tail;

  always_comb begin
    raw_ctl           = '0;
    raw_ctl[CI_SHIFT] = shift_clk_in;
    raw_ctl[CI_STORE] = store_clk_in;
    raw_ctl[CI_DATA]  = ser_in;
    raw_ctl[CI_CLR]   = clear_n;
    raw_ctl[CI_OE]    = oe_n;
  end

  slr_sync_bank #(.N(CI_COUNT), .IDLE(CI_IDLE)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (raw_ctl),
    .synced (syn_ctl)
  );

  slr_edge_bank #(.N(NCLK)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (syn_ctl[CI_STORE:CI_SHIFT]),
    .rise  (clk_rise)
  );

  assign shift_ev = clk_rise[CI_SHIFT];
  assign store_ev = clk_rise[CI_STORE];
  assign clr_act  = ~syn_ctl[CI_CLR];
  assign din_s    = syn_ctl[CI_DATA];

  slr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_ev (shift_ev),
    .din      (din_s),
    .clr_act  (clr_act),
    .chain    (chain),
    .tail     (tail)
  );

  slr_hold_bank #(.WIDTH(WIDTH)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_ev (store_ev),
    .clr_act  (clr_act),
    .chain_in (chain),
    .hold     (hold)
  );

  assign ser_out   = tail;
  assign par_data  = hold;
  assign par_drive = {WIDTH{~syn_ctl[CI_OE]}};

  AST_SIM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && store_ev && !clr_act) |=> hold == $past(chain)); // R9

  AST_CLEAR_SER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !ser_out); // R5

  AST_DRIVE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(par_drive) == 0) || ($countones(par_drive) == WIDTH)); // R7
endmodule

// File: tb/test_serial_latch_reg.sv
module test_serial_latch_reg;
  localparam int W = 8;
  localparam int NV = 6;
  // each row: {store after loading, 8-bit word sent MSB first}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'hFF},
    {1'b1, 8'h00}, {1'b1, 8'h81}, {1'b1, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sh = 1'b0, st = 1'b0, sd = 1'b0, clr = 1'b1, oe = 1'b0;
  logic ser_out;
  logic [W-1:0] par_data, par_drive;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [W-1:0] m_chain = '0, m_hold = '0;

  always #2 clk = ~clk;

  serial_latch_reg #(.WIDTH(W)) i_serial_latch_reg (
    .clk(clk), .rst_n(rst_n), .shift_clk_in(sh), .store_clk_in(st),
    .ser_in(sd), .clear_n(clr), .oe_n(oe), .ser_out(ser_out),
    .par_data(par_data), .par_drive(par_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one pulse on the chosen clock pins, model updated from the requirements
  task automatic pulse(input logic do_sh, input logic do_st, input logic bit_in);
    @(negedge clk);
    sd = bit_in; sh = do_sh; st = do_st;
    idle(5);
    sh = 1'b0; st = 1'b0;
    idle(5);
    if (!clr) begin
      if (do_st) m_hold = '0;
      m_chain = '0;
    end else begin
      if (do_st) m_hold = m_chain;
      if (do_sh) m_chain = {m_chain[W-2:0], bit_in};
    end
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int b = W-1; b >= 0; b--) begin
      pulse(1'b1, 1'b0, w[b]);
      chk("R3 ser_out tail", ser_out, m_chain[W-1]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R11 reset state
    chk("R11 par_data", par_data, 0);
    chk("R11 ser_out", ser_out, 0);
    chk("R7 drive on", par_drive, 8'hFF);

    // table walk
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v][7:0]);
      if (VEC[v][8]) pulse(1'b0, 1'b1, 1'b0);
      chk("R2 par_data", par_data, m_hold);
      if (VEC[v][8]) chk("R1 word order", par_data, VEC[v][7:0]);
    end

    // R2 partial shift, no store: output unchanged
    send_word(8'h5A);
    pulse(1'b1, 1'b0, 1'b1); pulse(1'b1, 1'b0, 1'b0); pulse(1'b1, 1'b0, 1'b1);
    chk("R2 no store steady", par_data, 8'h5A);
    chk("R3 ser_out after shifts", ser_out, m_chain[W-1]);

    // R12 latency: chain tail currently known; shift in so tail changes
    send_word(8'h80);
    chk("R12 setup", ser_out, 1);
    @(negedge clk); sh = 1'b1; sd = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 not before third edge", ser_out, 1);
    @(negedge clk);
    chk("R12 after third edge", ser_out, 0);
    m_chain = {m_chain[W-2:0], 1'b0};
    // R10 held high: no further shift
    idle(10);
    chk("R10 held high one shift", ser_out, m_chain[W-1]);
    sh = 1'b0; idle(5);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R10 held high stored", par_data, m_hold);
    chk("R10 held high value", par_data, 8'h00);

    // clear behaviour
    send_word(8'hC3);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R2 store C3", par_data, 8'hC3);
    send_word(8'hF0);
    chk("R3 tail before clear", ser_out, 1);
    @(negedge clk); clr = 1'b0; idle(5);
    m_chain = '0;
    chk("R5 ser_out low in clear", ser_out, 0);
    chk("R4 hold kept in clear", par_data, 8'hC3);
    pulse(1'b1, 1'b0, 1'b1);
    chk("R4 shift ignored", ser_out, 0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 store in clear zero", par_data, 8'h00);
    @(negedge clk); clr = 1'b1; idle(5);
    send_word(8'h01);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R4 chain was empty", par_data, 8'h01);

    // output enable
    @(negedge clk); oe = 1'b1; idle(5);
    chk("R7 drive off", par_drive, 8'h00);
    send_word(8'h96);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R8 ser_out with oe high", ser_out, m_chain[W-1]);
    chk("R8 store with oe high", par_data, 8'h96);
    chk("R7 still Z", par_drive, 8'h00);
    @(negedge clk); oe = 1'b0; idle(5);
    chk("R7 drive on again", par_drive, 8'hFF);
    chk("R8 value shown", par_data, 8'h96);

    // R9 simultaneous shift and store
    send_word(8'h6B);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R9 hold lags one pulse", par_data, 8'h6B);
    chk("R9 model", par_data, m_hold);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R9 second tied pulse", par_data, 8'hD7);
    chk("R3 tail after tied", ser_out, m_chain[W-1]);

    // R11 reset again mid-stream
    @(negedge clk); rst_n = 1'b0; idle(2);
    chk("R11 hold cleared", par_data, 0);
    chk("R11 ser_out cleared", ser_out, 0);
    rst_n = 1'b1; idle(4);
    m_chain = '0; m_hold = '0;
    pulse(1'b0, 1'b1, 1'b0);
    chk("R11 chain cleared", par_data, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule